// File: doc/BRIEF.md
# PCIe Root-Port Bring-Up Reset Sequencer

This block steps a PCIe root port from power-off to a configured, PHY-programmed state. A single `start` pulse drives both copies of PERST# low, the slot pin first and the controller's internal bit one cycle later. It then switches slot power on and keeps PERST# low for a parameterised number of cycles, which is 100 ms at the default clock. PERST# is then released, controller bit first and pin second.

After release the block turns on the auxiliary clock and holds the PHY reset. This keeps link training frozen while the power-up reset is released. The block then asks an external PHY-programming phase to run, using a `phy_cfg_start`/`phy_cfg_done` handshake. When that phase reports completion, the sequencer gates the aux clock off, drops the PHY hold, gates the clock back on, selects root-port mode on `dev_type` and raises `done`.

A `shutdown` request at any time re-asserts both PERST# outputs in the safe order, pin first, and returns the block to idle. This lets the link go down cleanly before a reboot. Every step takes one state and one clock edge. The hold time comes from the `HOLD_CYCLES` parameter, and a test build may shorten it.

Top module: `pcie_rp_bringup_seq`

## Requirements
- R1: A synchronous active-low reset sets the safe state on the next edge: `perst_pin_n`=0, `ctl_perst_n`=0, `slot_pwr_en`=0, `aux_clk_en`=0, `phy_hold_rst`=1, `pwrup_rst_n`=0, `phy_cfg_start`=0, `dev_type`=0 and `done`=0.
- R2: In idle, a `start` sampled at edge E0 re-applies the safe values at E0, except that `ctl_perst_n` is driven low at E1. The pin is never released while the controller bit is low.
- R3: `slot_pwr_en` rises at E2. `ctl_perst_n` rises at E3+HOLD_CYCLES and `perst_pin_n` rises one edge later, so PERST# stays low for at least HOLD_CYCLES cycles with power on.
- R4: `aux_clk_en` rises one edge after the pin is released. `pwrup_rst_n` rises two edges after that, and `phy_hold_rst` stays 1 throughout.
- R5: `phy_cfg_start` rises one edge after `pwrup_rst_n`. It stays high until an edge samples `phy_cfg_done`=1, and during that time `phy_hold_rst`, `pwrup_rst_n` and `aux_clk_en` are all 1.
- R6: The edge that samples `phy_cfg_done` drops `aux_clk_en`. The next edge clears `phy_hold_rst`, and the edge after that raises `aux_clk_en` again.
- R7: One edge after the clock returns, `dev_type` becomes 4 (the root-port code). `done` rises one edge later and then holds.
- R8: `start` has no effect outside idle; the sequence timing is unchanged.
- R9: A `shutdown` sampled at an edge drives `perst_pin_n` low and clears `done` and `phy_cfg_start` at that edge, and drives `ctl_perst_n` low on the next edge. The block then waits in idle. Slot power, clocks and `dev_type` keep their values. `shutdown` wins over a simultaneous `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin power-up sequence (idle only) |
| shutdown | input | 1 | Re-assert PERST# and return to idle |
| phy_cfg_done | input | 1 | PHY programming phase finished |
| perst_pin_n | output | 1 | Board PERST# pin, low = reset |
| ctl_perst_n | output | 1 | Controller PERST# bit, low = reset |
| slot_pwr_en | output | 1 | Slot power enable |
| aux_clk_en | output | 1 | Auxiliary clock enable |
| phy_hold_rst | output | 1 | Hold link training/PHY in reset |
| pwrup_rst_n | output | 1 | Power-up reset, low = held |
| phy_cfg_start | output | 1 | Request PHY programming phase |
| dev_type | output | DEV_W | Device-type code, 4 = root port |
| done | output | 1 | Sequence complete |

## Verification
Every output is registered from the next-state value. A result therefore appears at the same edge that samples its cause, and later steps follow one edge apart. The exceptions are the HOLD_CYCLES window and the wait for `phy_cfg_done`. The bench counts falling edges after the edge that takes `start` and records the first index at which each output changes. It compares that index with the offset stated in R2 to R7, shifted by the PHY-phase delay it injected. Shutdown and reset results are sampled at the first falling edge after the causing edge, and the controller bit at the falling edge after that.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [4:0] {
    ST_IDLE, ST_PIN_LO, ST_CTL_LO, ST_PWR_ON, ST_HOLD,
    ST_CTL_HI, ST_PIN_HI, ST_AUX_ON, ST_HOLD_SET, ST_PUP_REL,
    ST_PHY_CFG, ST_AUX_OFF, ST_HOLD_CLR, ST_AUX_REON, ST_DEVTYPE,
    ST_DONE, ST_SHUT_PIN, ST_SHUT_CTL
  } step_e;

  typedef struct packed {
    logic pin_n;
    logic ctl_n;
    logic pwr;
    logic aux;
    logic hold;
    logic pup_n;
    logic cfg;
    logic done;
  } drive_t;

  localparam drive_t DRIVE_SAFE = '{pin_n: 1'b0, ctl_n: 1'b0, pwr: 1'b0,
                                    aux: 1'b0, hold: 1'b1, pup_n: 1'b0,
                                    cfg: 1'b0, done: 1'b0};
endpackage

// File: rtl/prs_hold_timer.sv
module prs_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 12_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int unsigned CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;

  generate
    if (HOLD_CYCLES <= 1) begin : g_single
      assign expired = run;
    end else begin : g_count
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + 1'b1;
      end
      assign expired = run && (cnt == CNT_W'(HOLD_CYCLES - 1));
    end
  endgenerate
endmodule

// File: rtl/prs_step_ctrl.sv
module prs_step_ctrl
  import prs_pkg::*;
(
  input  step_e cur,
  input  logic  start,
  input  logic  shutdown,
  input  logic  hold_expired,
  input  logic  phy_cfg_done,
  output step_e nxt
);
  always_comb begin
    nxt = cur;
    if (shutdown && cur != ST_SHUT_PIN && cur != ST_SHUT_CTL) begin
      nxt = ST_SHUT_PIN;
    end else begin
      case (cur)
        ST_IDLE:     if (start) nxt = ST_PIN_LO;
        ST_PIN_LO:   nxt = ST_CTL_LO;
        ST_CTL_LO:   nxt = ST_PWR_ON;
        ST_PWR_ON:   nxt = ST_HOLD;
        ST_HOLD:     if (hold_expired) nxt = ST_CTL_HI;
        ST_CTL_HI:   nxt = ST_PIN_HI;
        ST_PIN_HI:   nxt = ST_AUX_ON;
        ST_AUX_ON:   nxt = ST_HOLD_SET;
        ST_HOLD_SET: nxt = ST_PUP_REL;
        ST_PUP_REL:  nxt = ST_PHY_CFG;
        ST_PHY_CFG:  if (phy_cfg_done) nxt = ST_AUX_OFF;
        ST_AUX_OFF:  nxt = ST_HOLD_CLR;
        ST_HOLD_CLR: nxt = ST_AUX_REON;
        ST_AUX_REON: nxt = ST_DEVTYPE;
        ST_DEVTYPE:  nxt = ST_DONE;
        ST_DONE:     nxt = ST_DONE;
        ST_SHUT_PIN: nxt = ST_SHUT_CTL;
        ST_SHUT_CTL: nxt = ST_IDLE;
        default:     nxt = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prs_drive_reg.sv
module prs_drive_reg
  import prs_pkg::*;
#(
  parameter int unsigned DEV_W     = 4,
  parameter int unsigned ROOT_CODE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            nxt,
  output drive_t           drv,
  output logic [DEV_W-1:0] dev_type
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv      <= DRIVE_SAFE;
      dev_type <= '0;
    end else begin
      drv.cfg  <= (nxt == ST_PHY_CFG);
      drv.done <= (nxt == ST_DONE);
      case (nxt)
        ST_PIN_LO: begin
          drv.pin_n <= 1'b0;
          drv.pwr   <= 1'b0;
          drv.aux   <= 1'b0;
          drv.hold  <= 1'b1;
          drv.pup_n <= 1'b0;
          dev_type  <= '0;
        end
        ST_CTL_LO, ST_SHUT_CTL: drv.ctl_n <= 1'b0;
        ST_PWR_ON:              drv.pwr   <= 1'b1;
        ST_CTL_HI:              drv.ctl_n <= 1'b1;
        ST_PIN_HI:              drv.pin_n <= 1'b1;
        ST_AUX_ON, ST_AUX_REON: drv.aux   <= 1'b1;
        ST_HOLD_SET:            drv.hold  <= 1'b1;
        ST_PUP_REL:             drv.pup_n <= 1'b1;
        ST_AUX_OFF:             drv.aux   <= 1'b0;
        ST_HOLD_CLR:            drv.hold  <= 1'b0;
        ST_DEVTYPE:             dev_type  <= DEV_W'(ROOT_CODE);
        ST_SHUT_PIN:            drv.pin_n <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pcie_rp_bringup_seq.sv
module pcie_rp_bringup_seq
  import prs_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 12_500_000,
  parameter int unsigned DEV_W       = 4,
  parameter int unsigned ROOT_CODE   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             shutdown,
  input  logic             phy_cfg_done,
  output logic             perst_pin_n,
  output logic             ctl_perst_n,
  output logic             slot_pwr_en,
  output logic             aux_clk_en,
  output logic             phy_hold_rst,
  output logic             pwrup_rst_n,
  output logic             phy_cfg_start,
  output logic [DEV_W-1:0] dev_type,
  output logic             done
);
  step_e  cur, nxt;
  logic   hold_expired;
  drive_t drv;

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= ST_IDLE;
    else        cur <= nxt;
  end

  prs_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cur == ST_HOLD),
    .expired (hold_expired)
  );

  prs_step_ctrl u_ctrl (
    .cur          (cur),
    .start        (start),
    .shutdown     (shutdown),
    .hold_expired (hold_expired),
    .phy_cfg_done (phy_cfg_done),
    .nxt          (nxt)
  );

  prs_drive_reg #(.DEV_W(DEV_W), .ROOT_CODE(ROOT_CODE)) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .nxt      (nxt),
    .drv      (drv),
    .dev_type (dev_type)
  );

  assign perst_pin_n   = drv.pin_n;
  assign ctl_perst_n   = drv.ctl_n;
  assign slot_pwr_en   = drv.pwr;
  assign aux_clk_en    = drv.aux;
  assign phy_hold_rst  = drv.hold;
  assign pwrup_rst_n   = drv.pup_n;
  assign phy_cfg_start = drv.cfg;
  assign done          = drv.done;
endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
  parameter int unsigned HOLD_CYCLES = 12_500_000,
  parameter int unsigned DEV_W       = 4,
  parameter int unsigned ROOT_CODE   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shutdown,
  input logic             phy_cfg_done,
  input logic             perst_pin_n,
  input logic             ctl_perst_n,
  input logic             slot_pwr_en,
  input logic             aux_clk_en,
  input logic             phy_hold_rst,
  input logic             pwrup_rst_n,
  input logic             phy_cfg_start,
  input logic [DEV_W-1:0] dev_type,
  input logic             done
);
  logic [31:0] pwr_age;
  always_ff @(posedge clk) begin
    if (!rst_n || !slot_pwr_en) pwr_age <= '0;
    else if (pwr_age != 32'hFFFF_FFFF) pwr_age <= pwr_age + 1'b1;
  end

  assert_pin_after_ctl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(perst_pin_n && !ctl_perst_n));

  assert_nopower_in_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_pwr_en |-> !perst_pin_n);

  assert_hold_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perst_pin_n) |-> (slot_pwr_en && pwr_age >= 32'(HOLD_CYCLES)));

  assert_cfg_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    phy_cfg_start |-> (phy_hold_rst && pwrup_rst_n && aux_clk_en));

  assert_cfg_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_cfg_start && !phy_cfg_done && !shutdown) |=> phy_cfg_start);

  assert_done_root_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dev_type == DEV_W'(ROOT_CODE) && !phy_hold_rst && aux_clk_en));

  assert_shutdown_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (!perst_pin_n && !done));
endmodule

bind pcie_rp_bringup_seq prs_checker #(
  .HOLD_CYCLES(HOLD_CYCLES), .DEV_W(DEV_W), .ROOT_CODE(ROOT_CODE)
) u_prs_chk (
  .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .phy_cfg_done(phy_cfg_done),
  .perst_pin_n(perst_pin_n), .ctl_perst_n(ctl_perst_n), .slot_pwr_en(slot_pwr_en),
  .aux_clk_en(aux_clk_en), .phy_hold_rst(phy_hold_rst), .pwrup_rst_n(pwrup_rst_n),
  .phy_cfg_start(phy_cfg_start), .dev_type(dev_type), .done(done)
);

// File: tb/test_pcie_rp_bringup_seq.sv
module test_pcie_rp_bringup_seq;
  localparam int H = 6;
  localparam int NROW = 4;
  // columns: PHY-phase delay, restart-pulse index (-1 none), expected done index
  localparam int TBL [NROW][3] = '{
    '{0, -1, 13 + H},
    '{3, -1, 16 + H},
    '{10, 4, 23 + H},
    '{1, 12, 14 + H}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0, start = 1'b0, shutdown = 1'b0, phy_cfg_done = 1'b0;
  logic perst_pin_n, ctl_perst_n, slot_pwr_en, aux_clk_en;
  logic phy_hold_rst, pwrup_rst_n, phy_cfg_start, done;
  logic [3:0] dev_type;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  pcie_rp_bringup_seq #(.HOLD_CYCLES(H)) i_pcie_rp_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .shutdown(shutdown),
    .phy_cfg_done(phy_cfg_done), .perst_pin_n(perst_pin_n),
    .ctl_perst_n(ctl_perst_n), .slot_pwr_en(slot_pwr_en),
    .aux_clk_en(aux_clk_en), .phy_hold_rst(phy_hold_rst),
    .pwrup_rst_n(pwrup_rst_n), .phy_cfg_start(phy_cfg_start),
    .dev_type(dev_type), .done(done)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_safe(string req);
    check({req, " pin"}, perst_pin_n, 0);
    check({req, " ctl"}, ctl_perst_n, 0);
    check({req, " pwr"}, slot_pwr_en, 0);
    check({req, " aux"}, aux_clk_en, 0);
    check({req, " hold"}, phy_hold_rst, 1);
    check({req, " pup"}, pwrup_rst_n, 0);
    check({req, " cfg"}, phy_cfg_start, 0);
    check({req, " dev"}, dev_type, 0);
    check({req, " done"}, done, 0);
  endtask

  task automatic run_seq(int d, int rs, int exp_done);
    int t_pwr = -1, t_ctl = -1, t_pin = -1, t_aux1 = -1, t_pup = -1, t_cfg = -1;
    int t_aoff = -1, t_h0 = -1, t_aux2 = -1, t_dev = -1, t_done = -1;
    start = 1'b1;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      start = (n == rs);
      if (n == 0) begin
        check("R2 restart pwr", slot_pwr_en, 0);
        check("R2 restart aux", aux_clk_en, 0);
        check("R2 restart dev", dev_type, 0);
      end
      if (n == 1) check("R2 ctl low", ctl_perst_n, 0);
      if (t_pwr < 0 && slot_pwr_en) t_pwr = n;
      if (t_ctl < 0 && ctl_perst_n) t_ctl = n;
      if (t_pin < 0 && perst_pin_n) t_pin = n;
      if (t_aux1 < 0 && aux_clk_en) t_aux1 = n;
      if (t_pup < 0 && pwrup_rst_n) t_pup = n;
      if (t_cfg < 0 && phy_cfg_start) begin
        t_cfg = n;
        check("R5 hold during cfg", phy_hold_rst, 1);
      end
      if (t_aoff < 0 && t_aux1 >= 0 && !aux_clk_en) t_aoff = n;
      if (t_h0 < 0 && !phy_hold_rst) t_h0 = n;
      if (t_aux2 < 0 && t_aoff >= 0 && aux_clk_en) t_aux2 = n;
      if (t_dev < 0 && dev_type == 4'd4) t_dev = n;
      phy_cfg_done = (t_cfg >= 0 && n == t_cfg + d);
      if (done) begin
        t_done = n;
        break;
      end
    end
    start = 1'b0;
    phy_cfg_done = 1'b0;
    check("R3 pwr", t_pwr, 2);
    check("R3 ctl release", t_ctl, 3 + H);
    check("R3 pin release", t_pin, 4 + H);
    check("R4 aux on", t_aux1, 5 + H);
    check("R4 pup release", t_pup, 7 + H);
    check("R5 cfg start", t_cfg, 8 + H);
    check("R6 aux off", t_aoff, 9 + H + d);
    check("R6 hold clear", t_h0, 10 + H + d);
    check("R6 aux back", t_aux2, 11 + H + d);
    check("R7 dev type", t_dev, 12 + H + d);
    check("R7/R8 done", t_done, exp_done);
    repeat (3) @(negedge clk);
    check("R7 done holds", done, 1);
  endtask

  task automatic shut_from_done();
    shutdown = 1'b1;
    @(negedge clk);
    shutdown = 1'b0;
    check("R9 pin low", perst_pin_n, 0);
    check("R9 ctl not yet", ctl_perst_n, 1);
    check("R9 done cleared", done, 0);
    check("R9 dev kept", dev_type, 4);
    check("R9 aux kept", aux_clk_en, 1);
    @(negedge clk);
    check("R9 ctl low", ctl_perst_n, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_safe("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < NROW; r++) begin
      run_seq(TBL[r][0], TBL[r][1], TBL[r][2]);
      shut_from_done();
    end

    // R9: shutdown during PHY phase abandons the sequence
    start = 1'b1;
    for (int n = 0; n < 50; n++) begin
      @(negedge clk);
      start = 1'b0;
      if (phy_cfg_start) break;
    end
    shutdown = 1'b1;
    @(negedge clk);
    shutdown = 1'b0;
    check("R9 mid cfg dropped", phy_cfg_start, 0);
    check("R9 mid pin low", perst_pin_n, 0);
    check("R9 mid ctl order", ctl_perst_n, 1);
    @(negedge clk);
    check("R9 mid ctl low", ctl_perst_n, 0);
    phy_cfg_done = 1'b1;
    @(negedge clk);
    phy_cfg_done = 1'b0;
    repeat (20) @(negedge clk);
    check("R9 mid no done", done, 0);
    check("R9 mid pwr kept", slot_pwr_en, 1);

    // R9/R8: shutdown wins over a simultaneous start
    start = 1'b1;
    shutdown = 1'b1;
    @(negedge clk);
    start = 1'b0;
    shutdown = 1'b0;
    check("R9 collision pwr", slot_pwr_en, 1);
    repeat (10) @(negedge clk);
    check("R9 collision no restart", slot_pwr_en, 1);
    check("R9 collision idle", done, 0);

    // R1: reset in the middle of a sequence
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_safe("R1 mid reset");
    rst_n = 1'b1;
    @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule